// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked system read and write an external asynchronous static RAM that is 16 bits wide and split into two byte lanes. On the host side, a request/ready handshake carries an address, write data, a read/write flag and a per-lane byte mask. Read data comes back with a one-cycle valid pulse. On the memory side, the controller drives the address, the active-low strobes (chip select, write enable, output enable and one enable per byte lane), and the output half and drive enable of the data bus. The bus pad itself sits outside the block.

Every memory timing minimum is a parameter in nanoseconds. Each one is turned into a whole number of clock cycles by rounding up against the clock period. A write runs in three timed phases: setup, strobe and recovery. A read holds select and output enable for the longest access or cycle minimum. A write that follows a read waits for a turnaround gap first, so the memory's output drivers have released before the controller drives the bus. All strobes come straight from flops.

With the default timing (10 ns clock, 55 ns cycles, 35 ns write pulse, 40 ns select-to-write-end, 25 ns data setup, 20 ns output release), the phase lengths are: setup 1 cycle, strobe 4, recovery 1, read 6 and turnaround 2.

Top module: `sram_async_ctrl`

## Requirements
- R1: `req_ready` is high only in the idle state after reset. A request is taken on a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is low on the next cycle.
- R2: A write first holds chip select low, the selected lane enables low, write enable high and the bus driven for SET cycles. It then holds write enable low for exactly WP cycles with address and data steady. WP = max(1, ceil(tWP/T)) and SET = max(1, max(ceil(tAW/T), ceil(tDW/T)) - WP).
- R3: After a write is accepted, `req_ready` returns SET+WP+REC+1 cycles later, where REC = max(1, ceil(tWC/T) - SET - WP). A write that follows a read adds TA cycles. With the defaults this is 7, or 9 after a read.
- R4: A read holds chip select and output enable low and write enable high for RD = max(1, ceil(tRC/T), ceil(tAA/T)) cycles. The bus is sampled at the end of the last of those cycles. `rsp_valid` is high for exactly one cycle, RD+1 cycles after acceptance (7 with the defaults).
- R5: Mask bit 0 selects `mem_be_n[0]` and data bits 7:0. Mask bit 1 selects `mem_be_n[1]` and bits 15:8. A write leaves unselected lanes of the memory word unchanged. A read returns unselected lanes as zero.
- R6: A request with mask 00 never pulls a lane enable low and changes no memory word. As a read it returns zero. Its cycle timing is the same as for any other mask.
- R7: `mem_addr` changes only while chip select is high.
- R8: `mem_dq_drive` is high only during write setup and strobe. It is never high while output enable is low. It falls on the same clock edge on which write enable rises.
- R9: After output enable rises, the bus is not driven for at least TA = max(1, ceil(tHZ/T)) cycles.
- R10: While reset is held, all strobes and lane enables are high, the bus is not driven, and `req_ready` and `rsp_valid` are low.
- R11: Write enable and output enable are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 8*LANE_N | Write data |
| req_be | input | LANE_N | Byte-lane mask, bit 0 = low byte |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 8*LANE_N | Read data, unselected lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | LANE_N | Lane enables, active low, bit 0 = low byte |
| mem_dq_out | output | 8*LANE_N | Data toward the bus |
| mem_dq_drive | output | 1 | Bus drive enable |
| mem_dq_in | input | 8*LANE_N | Data from the bus |

## Verification
The bench runs a behavioural memory that follows the select and enable truth table. This memory keeps driving for TA cycles after output enable rises, returns garbage until the access count has elapsed, and records how long each write strobe and its data lasted. Full-word, single-lane and empty masks are each written and read back. This separates a swapped or ignored lane enable from a correct one and shows whether unselected read lanes are zeroed. A read immediately followed by a write exposes a missing or short turnaround through bus contention. Random mixes of masks, directions and a small address range check read data, latency and final memory contents against a reference array.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_TURN = 3'd1,
    ST_WSET = 3'd2,
    ST_WSTB = 3'd3,
    ST_WREC = 3'd4,
    ST_RACC = 3'd5
  } ctrl_state_e;

  function automatic int ns2cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = load_i | (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) cnt_d = val_i;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int SET_CYC = 1,
  parameter int WP_CYC  = 4,
  parameter int REC_CYC = 1,
  parameter int RD_CYC  = 6,
  parameter int TA_CYC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_i,
  input  logic             acc_wr_i,
  input  logic             tmr_done_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             ready_o,
  output logic             lane_on_o,
  output logic             capture_o,
  output logic             cs_n_o,
  output logic             we_n_o,
  output logic             oe_n_o,
  output logic             drive_o
);

  ctrl_state_e state_q, state_d;
  logic        rd_last_q, rd_last_d;
  logic        ready_q, cs_n_q, we_n_q, oe_n_q, drive_q;

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (acc_i) state_d = !acc_wr_i ? ST_RACC : (rd_last_q ? ST_TURN : ST_WSET);
      ST_TURN: if (tmr_done_i) state_d = ST_WSET;
      ST_WSET: if (tmr_done_i) state_d = ST_WSTB;
      ST_WSTB: if (tmr_done_i) state_d = ST_WREC;
      ST_WREC: if (tmr_done_i) state_d = ST_IDLE;
      ST_RACC: if (tmr_done_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign capture_o  = (state_q == ST_RACC) && tmr_done_i;
  assign tmr_load_o = (state_d != state_q);
  assign lane_on_o  = (state_d == ST_WSET) || (state_d == ST_WSTB) || (state_d == ST_RACC);

  always_comb begin
    rd_last_d = rd_last_q;
    if (capture_o) rd_last_d = 1'b1;
    else if (state_d == ST_WSET) rd_last_d = 1'b0;
  end

  always_comb begin
    unique case (state_d)
      ST_TURN: tmr_val_o = CNT_W'(TA_CYC - 1);
      ST_WSET: tmr_val_o = CNT_W'(SET_CYC - 1);
      ST_WSTB: tmr_val_o = CNT_W'(WP_CYC - 1);
      ST_WREC: tmr_val_o = CNT_W'(REC_CYC - 1);
      ST_RACC: tmr_val_o = CNT_W'(RD_CYC - 1);
      default: tmr_val_o = '0;
    endcase
  end

  // registers: strobes come straight from flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rd_last_q <= 1'b0;
      ready_q   <= 1'b0;
      cs_n_q    <= 1'b1;
      we_n_q    <= 1'b1;
      oe_n_q    <= 1'b1;
      drive_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      rd_last_q <= rd_last_d;
      ready_q   <= (state_d == ST_IDLE);
      cs_n_q    <= !((state_d == ST_WSET) || (state_d == ST_WSTB) || (state_d == ST_RACC));
      we_n_q    <= !(state_d == ST_WSTB);
      oe_n_q    <= !(state_d == ST_RACC);
      drive_q   <= (state_d == ST_WSET) || (state_d == ST_WSTB);
    end
  end

  assign ready_o = ready_q;
  assign cs_n_o  = cs_n_q;
  assign we_n_o  = we_n_q;
  assign oe_n_o  = oe_n_q;
  assign drive_o = drive_q;

endmodule

// File: rtl/sram_lane_io.sv
module sram_lane_io #(
  parameter int LANE_N = 2,
  localparam int DATA_W = 8 * LANE_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lane_on_i,
  input  logic [LANE_N-1:0] be_next_i,
  input  logic [LANE_N-1:0] be_cur_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] dq_in_i,
  output logic [LANE_N-1:0] be_n_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);

  logic [LANE_N-1:0] be_n_d, be_n_q;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              rvalid_q;

  for (genvar l = 0; l < LANE_N; l++) begin : g_lane
    assign be_n_d[l]        = !(lane_on_i && be_next_i[l]);
    assign rdata_d[8*l +: 8] = be_cur_i[l] ? dq_in_i[8*l +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      be_n_q   <= '1;
      rvalid_q <= 1'b0;
    end else begin
      be_n_q   <= be_n_d;
      rvalid_q <= capture_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (capture_i) rdata_q <= rdata_d;
  end

  assign be_n_o   = be_n_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int LANE_N  = 2,
  parameter int CLK_NS  = 10,
  parameter int T_WC_NS = 55,
  parameter int T_WP_NS = 35,
  parameter int T_AW_NS = 40,
  parameter int T_DW_NS = 25,
  parameter int T_RC_NS = 55,
  parameter int T_AA_NS = 55,
  parameter int T_HZ_NS = 20,
  parameter int CNT_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [8*LANE_N-1:0]   req_wdata,
  input  logic [LANE_N-1:0]     req_be,
  output logic                  rsp_valid,
  output logic [8*LANE_N-1:0]   rsp_rdata,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_cs_n,
  output logic                  mem_we_n,
  output logic                  mem_oe_n,
  output logic [LANE_N-1:0]     mem_be_n,
  output logic [8*LANE_N-1:0]   mem_dq_out,
  output logic                  mem_dq_drive,
  input  logic [8*LANE_N-1:0]   mem_dq_in
);

  localparam int DATA_W  = 8 * LANE_N;
  localparam int WP_CYC  = at_least_one(ns2cyc(T_WP_NS, CLK_NS));
  localparam int SET_CYC = at_least_one(imax(ns2cyc(T_AW_NS, CLK_NS),
                                             ns2cyc(T_DW_NS, CLK_NS)) - WP_CYC);
  localparam int REC_CYC = at_least_one(ns2cyc(T_WC_NS, CLK_NS) - SET_CYC - WP_CYC);
  localparam int RD_CYC  = at_least_one(imax(ns2cyc(T_RC_NS, CLK_NS),
                                             ns2cyc(T_AA_NS, CLK_NS)));
  localparam int TA_CYC  = at_least_one(ns2cyc(T_HZ_NS, CLK_NS));

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  logic              acc;
  logic              tmr_load, tmr_done, lane_on, capture;
  logic [CNT_W-1:0]  tmr_val;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANE_N-1:0] be_q, be_next;

  assign acc     = req_valid && req_ready;
  assign be_next = acc ? req_be : be_q;

  // request hold registers, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (acc) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  sram_ctrl_fsm #(
    .CNT_W  (CNT_W),
    .SET_CYC(SET_CYC),
    .WP_CYC (WP_CYC),
    .REC_CYC(REC_CYC),
    .RD_CYC (RD_CYC),
    .TA_CYC (TA_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .acc_i     (acc),
    .acc_wr_i  (req_write),
    .tmr_done_i(tmr_done),
    .tmr_load_o(tmr_load),
    .tmr_val_o (tmr_val),
    .ready_o   (req_ready),
    .lane_on_o (lane_on),
    .capture_o (capture),
    .cs_n_o    (mem_cs_n),
    .we_n_o    (mem_we_n),
    .oe_n_o    (mem_oe_n),
    .drive_o   (mem_dq_drive)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n_s),
    .load_i(tmr_load),
    .val_i (tmr_val),
    .done_o(tmr_done)
  );

  sram_lane_io #(.LANE_N(LANE_N)) u_lanes (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .lane_on_i(lane_on),
    .be_next_i(be_next),
    .be_cur_i (be_q),
    .capture_i(capture),
    .dq_in_i  (mem_dq_in),
    .be_n_o   (mem_be_n),
    .rdata_o  (rsp_rdata),
    .rvalid_o (rsp_valid)
  );

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 18,
  parameter int LANE_N = 2,
  parameter int CNT_W  = 8,
  parameter int WP_CYC = 4,
  parameter int TA_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [LANE_N-1:0] mem_be_n,
  input logic              mem_dq_drive
);

  logic [CNT_W-1:0] wlow_cnt;
  logic [CNT_W-1:0] since_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wlow_cnt <= '0;
    else if (mem_we_n) wlow_cnt <= '0;
    else if (wlow_cnt != '1) wlow_cnt <= wlow_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_oe <= '1;
    else if (!mem_oe_n) since_oe <= '0;
    else if (since_oe != '1) since_oe <= since_oe + 1'b1;
  end

  a_r1_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r2_we_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wlow_cnt == CNT_W'(WP_CYC)));

  a_r4_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r6_lane_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_be_n != '1) |-> !mem_cs_n);

  a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  a_r8_drive_not_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_drive |-> mem_oe_n);

  a_r8_drive_under_we: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_drive);

  a_r8_release_at_we_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_dq_drive);

  a_r9_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_drive |-> (since_oe >= CNT_W'(TA_CYC)));

  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

endmodule

bind sram_async_ctrl sram_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .LANE_N(LANE_N),
  .CNT_W (CNT_W),
  .WP_CYC(WP_CYC),
  .TA_CYC(TA_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .mem_addr    (mem_addr),
  .mem_cs_n    (mem_cs_n),
  .mem_we_n    (mem_we_n),
  .mem_oe_n    (mem_oe_n),
  .mem_be_n    (mem_be_n),
  .mem_dq_drive(mem_dq_drive)
);

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 10;
  localparam int WORDS = 1 << AW;
  localparam int T_WC = 55, T_WP = 35, T_AW = 40, T_DW = 25;
  localparam int T_RC = 55, T_AA = 55, T_HZ = 20;

  function automatic int cyc(input int ns);
    return (ns + CLK_PERIOD - 1) / CLK_PERIOD;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int WP  = mx(1, cyc(T_WP));
  localparam int SET = mx(1, mx(cyc(T_AW), cyc(T_DW)) - WP);
  localparam int REC = mx(1, cyc(T_WC) - SET - WP);
  localparam int RD  = mx(1, mx(cyc(T_RC), cyc(T_AA)));
  localparam int TA  = mx(1, cyc(T_HZ));

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic [1:0]    req_be = '0;
  logic          req_ready, rsp_valid;
  logic [15:0]   rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_cs_n, mem_we_n, mem_oe_n, mem_dq_drive;
  logic [1:0]    mem_be_n;
  logic [15:0]   mem_dq_out;
  logic [15:0]   bus = 16'h5A5A;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sram_async_ctrl #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
    .mem_dq_drive(mem_dq_drive), .mem_dq_in(bus)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] init_word(input int i);
    return 16'(i * 40503 + 7);
  endfunction

  // behavioural memory, evaluated on falling edges
  logic [15:0]   marr [WORDS];
  logic [15:0]   ref_arr [WORDS];
  int            hz = 0, acc_cnt = 0, wcnt = 0, dcnt = 0, cs_cnt = 0;
  int            commit_cnt = 0, lane_cnt = 0, last_pulse = 0;
  bit            mdrive = 0, prev_rd = 0, prev_w = 0, prev_drive = 0;
  logic [15:0]   mval = '0, pend = '0, prev_dq = '0;
  logic [1:0]    pend_ln = '0;
  logic [AW-1:0] prev_a = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit act_rd, act_w;
      act_rd = !mem_cs_n && !mem_oe_n && mem_we_n && (mem_be_n != 2'b11);
      act_w  = !mem_cs_n && !mem_we_n && (mem_be_n != 2'b11);
      if (mem_be_n != 2'b11) lane_cnt++;
      // read side
      if (act_rd) begin
        acc_cnt = (prev_rd && mem_addr == prev_a) ? acc_cnt + 1 : 1;
        hz = TA;
        mdrive = 1;
        for (int l = 0; l < 2; l++)
          mval[8*l +: 8] = mem_be_n[l] ? 8'hEE :
                           (acc_cnt >= cyc(T_AA) ? marr[mem_addr][8*l +: 8] : 8'hB5);
      end else if (hz > 0) begin
        hz--;
        mdrive = 1;
      end else begin
        mdrive = 0;
      end
      if (mdrive && mem_dq_drive) begin
        checks++; errors++;
        $display("FAIL R9 bus contention actual %h expected %h", 1, 0);
      end
      bus = mem_dq_drive ? mem_dq_out : (mdrive ? mval : 16'h5A5A);
      // write side
      if (act_w) begin
        if (prev_w && mem_addr != prev_a) begin
          checks++; errors++;
          $display("FAIL R7 address moved in write actual %h expected %h", mem_addr, prev_a);
        end
        wcnt++;
        dcnt = (mem_dq_drive && prev_drive && mem_dq_out == prev_dq) ? dcnt + 1 : (mem_dq_drive ? 1 : 0);
        pend = bus;
        pend_ln = ~mem_be_n;
      end else if (prev_w) begin
        check(wcnt == WP, "R2 write pulse cycles", wcnt, WP);
        check(dcnt >= cyc(T_DW), "R2 data setup cycles", dcnt, cyc(T_DW));
        check(cs_cnt >= cyc(T_AW), "R2 select before write end", cs_cnt, cyc(T_AW));
        for (int l = 0; l < 2; l++)
          if (pend_ln[l]) marr[prev_a][8*l +: 8] = pend[8*l +: 8];
        last_pulse = wcnt;
        commit_cnt++;
        wcnt = 0;
      end
      cs_cnt = mem_cs_n ? 0 : cs_cnt + 1;
      prev_rd = act_rd;
      prev_w = act_w;
      prev_a = mem_addr;
      prev_drive = mem_dq_drive;
      prev_dq = mem_dq_out;
    end
  end

  bit last_rd = 0;

  task automatic run_op(input bit wr, input logic [AW-1:0] a, input logic [15:0] d,
                        input logic [1:0] be, input string tag);
    int n, c0, l0, exp_n;
    logic [15:0] exp_d;
    n = 0;
    while (!req_ready && n < 50) begin @(negedge clk); n++; end
    c0 = commit_cnt;
    l0 = lane_cnt;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check(!req_ready, {"R1 ready after accept ", tag}, req_ready, 0);
    n = 1;
    if (wr) begin
      exp_n = (last_rd ? TA : 0) + SET + WP + REC + 1;
      while (!req_ready && n < 100) begin @(negedge clk); n++; end
      check(n == exp_n, {"R3 write occupancy ", tag}, n, exp_n);
      if (be == 2'b00) begin
        check(commit_cnt == c0, {"R6 no write for empty mask ", tag}, commit_cnt, c0);
        check(lane_cnt == l0, {"R6 no lane enable for empty mask ", tag}, lane_cnt, l0);
      end else begin
        check(last_pulse == WP, {"R2 strobe length ", tag}, last_pulse, WP);
      end
      for (int l = 0; l < 2; l++)
        if (be[l]) ref_arr[a][8*l +: 8] = d[8*l +: 8];
      last_rd = 0;
    end else begin
      exp_n = RD + 1;
      for (int l = 0; l < 2; l++) exp_d[8*l +: 8] = be[l] ? ref_arr[a][8*l +: 8] : 8'h00;
      while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
      check(n == exp_n, {"R4 read latency ", tag}, n, exp_n);
      check(rsp_rdata == exp_d, {"R5 read data ", tag}, rsp_rdata, exp_d);
      @(negedge clk);
      check(!rsp_valid, {"R4 valid is one cycle ", tag}, rsp_valid, 0);
      last_rd = 1;
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual %h expected %h", 1, 0);
    finish_run();
  end

  initial begin
    int seed;
    for (int i = 0; i < WORDS; i++) begin
      marr[i] = init_word(i);
      ref_arr[i] = init_word(i);
    end
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R10: reset state
    check(mem_cs_n && mem_we_n && mem_oe_n, "R10 strobes high in reset", {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
    check(mem_be_n == 2'b11, "R10 lane enables high in reset", mem_be_n, 2'b11);
    check(!mem_dq_drive, "R10 bus released in reset", mem_dq_drive, 0);
    check(!req_ready && !rsp_valid, "R10 ready and valid low in reset", {req_ready, rsp_valid}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check(req_ready, "R1 ready after reset", req_ready, 1);

    // directed lane and mask cases
    run_op(1, 10'd5, 16'hA55A, 2'b11, "full write");
    run_op(0, 10'd5, 16'h0000, 2'b11, "full read");
    run_op(1, 10'd5, 16'h1234, 2'b01, "low lane write");
    run_op(0, 10'd5, 16'h0000, 2'b11, "after low lane");
    run_op(1, 10'd5, 16'h9876, 2'b10, "high lane write");
    run_op(0, 10'd5, 16'h0000, 2'b11, "after high lane");
    run_op(1, 10'd5, 16'hFFFF, 2'b00, "R6 empty write");
    run_op(0, 10'd5, 16'h0000, 2'b00, "R6 empty read");
    run_op(0, 10'd5, 16'h0000, 2'b11, "R6 after empty write");
    run_op(0, 10'd5, 16'h0000, 2'b01, "R5 low lane read");
    run_op(0, 10'd5, 16'h0000, 2'b10, "R5 high lane read");
    run_op(1, 10'd6, 16'hC0DE, 2'b11, "R9 write after read");
    run_op(1, 10'd7, 16'hBEEF, 2'b11, "back to back write");
    run_op(0, 10'd7, 16'h0000, 2'b11, "read after write");
    run_op(0, 10'd6, 16'h0000, 2'b11, "read after read");

    // random mix over a small address window
    for (int k = 0; k < 150; k++) begin
      logic [31:0] r;
      r = $urandom;
      run_op(r[0], AW'(r[7:4]), r[31:16], r[3:2], "random");
    end

    // R5: memory contents match the reference
    repeat (2) @(negedge clk);
    for (int i = 0; i < 16; i++)
      check(marr[i] == ref_arr[i], "R5 final memory word", marr[i], ref_arr[i]);
    finish_run();
  end

endmodule